// File: doc/BRIEF.md
# Ten-Step Leapfrog Noise Source

This block produces a stream of 10-bit pseudo-random samples for use as a video noise source. Inside is a 17-bit maximal-length shift register built on the recurrence x^17 + x^14 + 1. On every enabled clock the register moves forward ten single shifts, not one. The ten newest bits then form the low ten bits of the register, and that field is presented as the sample. As a result, two consecutive samples never reuse a bit. The sequence has period 2^17-1, which leaves a remainder of 1 when divided by 10, so stepping ten at a time still passes through every nonzero state before the sequence repeats.

The ten shifts are written as an unrolled chain of the single-step recurrence. That chain reduces to one combinational next-state function. A seed can be loaded at any time. A seed of zero would lock the register, so it is replaced by a fixed nonzero default, which is also the value that reset applies. A valid flag marks each cycle that follows an enabled advance.

Top module: `leapfrog_noise_gen`

## Requirements
- R1: While reset is high and in the cycle after it, the register holds the default state 17'h0ACE1, so `sample` reads 10'h0E1 and `sample_valid` is 0. Reset is synchronous and active high.
- R2: A clock with `seed_load` high and a nonzero `seed` loads the register with `seed`. In the next cycle `sample` equals `seed[9:0]` and `sample_valid` is 0.
- R3: A clock with `seed_load` high and `seed` equal to zero loads the default state 17'h0ACE1. `sample` then reads 10'h0E1.
- R4: `seed_load` takes priority over `en`. A clock with both high performs a load and no advance.
- R5: A clock with `en` high and `seed_load` low applies the single step ten times. In one step, the new bit is bit 16 XOR bit 13, the register shifts one place toward the MSB, and the new bit enters bit 0.
- R6: `sample_valid` is 1 in exactly the cycles that follow a clock with `en` high and `seed_load` low.
- R7: A clock with `en` low and `seed_load` low leaves the register unchanged and clears `sample_valid`.
- R8: After an advance, the full 17-bit state can be read at the ports as {previous `sample`[6:0], `sample`}. Starting from a loaded seed, the state first returns to that seed after exactly 2^17-1 advances.
- R9: The register never holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the register ten steps on this clock |
| seed_load | input | 1 | Load `seed` on this clock (a zero seed is replaced by the default) |
| seed | input | 17 | Seed value |
| sample | output | 10 | Low ten bits of the register |
| sample_valid | output | 1 | High in the cycle after an enabled advance |

## Verification
A wrong bit in the state shows up at `sample` either at once or within two advances. The low ten bits appear directly, and the upper seven bits shift into view on the next advance. This holds because the state after an advance is {previous sample[6:0], sample}. A wrong tap or a wrong step count makes the samples disagree with the reference within a few cycles of any load. A state that leaves the maximal cycle appears as an early or missing return to the seed over the full 2^17-1 advance run.

// File: rtl/leapfrog_pkg.sv
package leapfrog_pkg;

    localparam int LFSR_W        = 17;
    localparam int TAP_HI        = 17;
    localparam int TAP_LO        = 14;
    localparam int STEPS_PER_CLK = 10;
    localparam int SAMPLE_W      = 10;

    typedef logic [LFSR_W-1:0]   lfsr_state_t;
    typedef logic [SAMPLE_W-1:0] sample_t;

    localparam lfsr_state_t DEFAULT_SEED = 17'h0ACE1;

    typedef struct packed {
        logic    valid;
        sample_t data;
    } noise_word_t;

    // One shift of the recurrence: feedback from the two taps enters bit 0.
    function automatic lfsr_state_t lfsr_step(input lfsr_state_t s);
        logic fb;
        fb = s[TAP_HI-1] ^ s[TAP_LO-1];
        return {s[LFSR_W-2:0], fb};
    endfunction

    // The all-zero state is a fixed point, so it is never allowed in.
    function automatic lfsr_state_t sanitize_seed(input lfsr_state_t s);
        return (s == '0) ? DEFAULT_SEED : s;
    endfunction

endpackage

// File: rtl/leapfrog_next.sv
module leapfrog_next
    import leapfrog_pkg::*;
#(
    parameter int STEPS = STEPS_PER_CLK
) (
    input  lfsr_state_t cur_state,
    output lfsr_state_t next_state
);
    lfsr_state_t stage [STEPS+1];

    assign stage[0] = cur_state;

    // Unrolled chain of single steps; flattens to one next-state function.
    for (genvar i = 0; i < STEPS; i++) begin : g_step
        assign stage[i+1] = lfsr_step(stage[i]);
    end

    assign next_state = stage[STEPS];
endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg
    import leapfrog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  lfsr_state_t load_value,
    input  logic        advance,
    input  lfsr_state_t advanced,
    output lfsr_state_t state_q,
    output logic        adv_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DEFAULT_SEED;
            adv_q   <= 1'b0;
        end else if (load) begin
            state_q <= sanitize_seed(load_value);
            adv_q   <= 1'b0;
        end else if (advance) begin
            state_q <= advanced;
            adv_q   <= 1'b1;
        end else begin
            adv_q   <= 1'b0;
        end
    end
endmodule

// File: rtl/leapfrog_noise_gen.sv
module leapfrog_noise_gen
    import leapfrog_pkg::*;
#(
    parameter int STEPS = STEPS_PER_CLK
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                seed_load,
    input  logic [LFSR_W-1:0]   seed,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_valid
);
    lfsr_state_t state_q;
    lfsr_state_t state_adv;
    logic        adv_q;
    noise_word_t out_word;

    leapfrog_next #(.STEPS(STEPS)) u_next (
        .cur_state  (state_q),
        .next_state (state_adv)
    );

    lfsr_state_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .load       (seed_load),
        .load_value (seed),
        .advance    (en),
        .advanced   (state_adv),
        .state_q    (state_q),
        .adv_q      (adv_q)
    );

    assign out_word.valid = adv_q;
    assign out_word.data  = state_q[SAMPLE_W-1:0];

    assign sample       = out_word.data;
    assign sample_valid = out_word.valid;
endmodule

// File: rtl/leapfrog_noise_checker.sv
module leapfrog_noise_checker
    import leapfrog_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic                seed_load,
    input logic [LFSR_W-1:0]   seed,
    input logic [SAMPLE_W-1:0] sample,
    input logic                sample_valid,
    input lfsr_state_t         state_q
);
    assert_state_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!en && !seed_load) |=> ($stable(sample) && !sample_valid));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed != '0) |=> (sample == $past(seed[SAMPLE_W-1:0]) && !sample_valid));

    assert_zero_seed_R3: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed == '0) |=> (sample == DEFAULT_SEED[SAMPLE_W-1:0]));

    assert_valid_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_load) |=> sample_valid);

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (state_q[LFSR_W-1:SAMPLE_W] == $past(state_q[LFSR_W-SAMPLE_W-1:0])));
endmodule

bind leapfrog_noise_gen leapfrog_noise_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .seed_load    (seed_load),
    .seed         (seed),
    .sample       (sample),
    .sample_valid (sample_valid),
    .state_q      (state_q)
);

// File: tb/leapfrog_noise_gen_test.sv
module leapfrog_noise_gen_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PERIOD = 131071;
    localparam int DEF    = 'h0ACE1;

    logic       clk = 0;
    logic       rst = 1;
    logic       en = 0;
    logic       seed_load = 0;
    logic [16:0] seed = '0;
    logic [9:0] sample;
    logic       sample_valid;

    int checks = 0;
    int fails  = 0;
    int model;           // behavioural reference of the full state
    logic model_valid;

    always #10 clk = ~clk;   // 50 MHz

    leapfrog_noise_gen uut (
        .clk(clk), .rst(rst), .en(en), .seed_load(seed_load), .seed(seed),
        .sample(sample), .sample_valid(sample_valid)
    );

    function automatic int ten_steps(input int s);
        int v = s;
        for (int k = 0; k < 10; k++) begin
            int fb = ((v >> 16) ^ (v >> 13)) & 1;
            v = ((v * 2) + fb) % 131072;
        end
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: update the model from the inputs, then sample after the edge.
    task automatic tick(input string req);
        if (rst) begin
            model = DEF; model_valid = 0;
        end else if (seed_load) begin
            model = (seed == 0) ? DEF : int'(seed); model_valid = 0;
        end else if (en) begin
            model = ten_steps(model); model_valid = 1;
        end else begin
            model_valid = 0;
        end
        @(posedge clk);
        #2;
        check(req, int'(sample), model % 1024);
        check("R6", int'(sample_valid), int'(model_valid));
    endtask

    initial begin
        #(180000 * 20);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [9:0] prev;
        int first_ret;
        model = DEF; model_valid = 0;
        // R1: reset state
        repeat (3) tick("R1");
        rst = 0;
        tick("R1");
        check("R1", int'(sample), 'h0E1);

        // R5: free-running advance
        en = 1;
        repeat (20) tick("R5");

        // R7: hold with enable low
        en = 0;
        repeat (5) tick("R7");

        // R2 / R4: load with enable also high
        seed = 17'h1B3C5; seed_load = 1; en = 1;
        tick("R4");
        check("R2", int'(sample), 'h3C5);
        seed_load = 0;
        repeat (5) tick("R5");

        // R3: zero seed replaced by default
        seed = '0; seed_load = 1;
        tick("R3");
        check("R3", int'(sample), 'h0E1);
        seed_load = 0;

        // R5 / R7: mixed enable pattern
        for (int c = 0; c < 30; c++) begin
            en = ((c / 3) % 2) == 0;
            tick("R5");
        end

        // R8: full period from a loaded seed
        seed = 17'h12345; seed_load = 1; en = 0;
        tick("R2");
        seed_load = 0; en = 1;
        prev = sample;
        first_ret = 0;
        for (int k = 1; k <= PERIOD; k++) begin
            logic [16:0] full;
            tick("R5");
            full = {prev[6:0], sample};
            prev = sample;
            if (full == 17'h12345 && first_ret == 0) first_ret = k;
        end
        check("R8", first_ret, PERIOD);
        check("R9", int'(model != 0), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule